// File: doc/BRIEF.md
# Single-Cycle Four-Operation Processor Core

This block is a small non-pipelined 32-bit processor core. Each clock it fetches one instruction word from an instruction memory addressed by its program counter, decodes it, reads its register operands, and commits all of its effects at the next rising edge. Both memories sit outside the core. The instruction read is combinational. The data port has a combinational read and a write that is taken at the clock edge.

The instruction set has four operations: register add, branch-if-zero, load and store. Memory addresses and branch targets always come from registers. There are no immediates, and the PC counts in whole words, advancing by one. The core holds a 32-entry by 32-bit register file in which every entry, R0 included, is an ordinary writable register.

The core has no multi-cycle states. Its only sequencing is the operation selected by the 2-bit tag of the current instruction. ADD, BZ, LOAD and STORE are decoded with a unique case. The one transition is from the current PC to either PC+1 or a branch target.

Top module: `qc_core`

## Requirements
- R1: While rst_n is low, and after it is released, PC is 0 and all 32 registers read as 0, so imem_addr is 0 and any register operand presented on the data port is 0.
- R2: Instruction bits [31:30] hold the tag: 00 ADD, 01 BZ, 10 LOAD, 11 STORE. Field A is [29:25], field B is [24:20] and field C is [19:15]. Bits [14:0] have no effect.
- R3: ADD writes reg[B]+reg[C] modulo 2^32 into reg[A] at the clock edge and advances the PC by one, with dmem_we low.
- R4: BZ with reg[A] equal to 0 loads the PC with reg[B].
- R5: BZ with reg[A] not 0 advances the PC by one and changes neither registers nor memory (dmem_we low).
- R6: LOAD drives dmem_addr = reg[B] in the same cycle and writes dmem_rdata into reg[A] at the edge. The PC advances by one.
- R7: STORE drives dmem_we=1, dmem_addr=reg[B] and dmem_wdata=reg[A] in the same cycle, changes no register, and advances the PC by one.
- R8: R0 is writable and reads back the last value written to it.
- R9: imem_addr equals the PC, and exactly one instruction completes per clock.
- R10: When a source register is also the destination, the source reads the value from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Word address of the instruction to fetch (the PC) |
| imem_rdata | input | 32 | Instruction word, valid in the same cycle |
| dmem_addr | output | 32 | Data word address (reg[B]) |
| dmem_rdata | input | 32 | Data read word, valid in the same cycle |
| dmem_we | output | 1 | Data write enable, taken at the rising edge |
| dmem_wdata | output | 32 | Data write word (reg[A]) |

## Verification
The data-port results of an instruction (address, write enable, write data) are due in the same cycle the instruction is on imem_rdata. The PC and register results appear one edge later. The bench therefore checks every output at the falling edge, halfway through the cycle of the instruction, against a bench-side instruction model. It then steps that model, so the PC and each register result are compared one cycle later through imem_addr and through later memory operations. The register reset is observed while reset is still held, through the operands a store presents on the data port.

// File: rtl/qc_pkg.sv
package qc_pkg;
    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int REG_AW  = $clog2(NREGS);
    localparam int TAG_W   = 2;
    localparam int TAG_LSB = XLEN - TAG_W;
    localparam int FA_LSB  = TAG_LSB - REG_AW;
    localparam int FB_LSB  = FA_LSB - REG_AW;
    localparam int FC_LSB  = FB_LSB - REG_AW;

    typedef enum logic [TAG_W-1:0] {
        OP_ADD   = 2'b00,
        OP_BZ    = 2'b01,
        OP_LOAD  = 2'b10,
        OP_STORE = 2'b11
    } op_e;
endpackage

// File: rtl/qc_decode.sv
module qc_decode
    import qc_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output op_e               op,
    output logic [REG_AW-1:0] ra_idx,
    output logic [REG_AW-1:0] rb_idx,
    output logic [REG_AW-1:0] wr_idx,
    output logic              rf_we,
    output logic              wb_from_mem,
    output logic              mem_we,
    output logic              is_branch
);
    logic [REG_AW-1:0] fa, fb, fc;
    logic              unused_low;

    assign op         = op_e'(instr[XLEN-1 -: TAG_W]);
    assign fa         = instr[TAG_LSB-1 -: REG_AW];
    assign fb         = instr[FA_LSB-1 -: REG_AW];
    assign fc         = instr[FB_LSB-1 -: REG_AW];
    assign unused_low = ^instr[FC_LSB-1:0];

    always_comb begin
        ra_idx      = fa;
        rb_idx      = fb;
        wr_idx      = fa;
        rf_we       = 1'b0;
        wb_from_mem = 1'b0;
        mem_we      = 1'b0;
        is_branch   = 1'b0;
        unique case (op)
            OP_ADD: begin
                ra_idx = fb;
                rb_idx = fc;
                rf_we  = 1'b1;
            end
            OP_BZ: begin
                is_branch = 1'b1;
            end
            OP_LOAD: begin
                rf_we       = 1'b1;
                wb_from_mem = 1'b1;
            end
            OP_STORE: begin
                mem_we = 1'b1;
            end
        endcase
    end

    always_comb begin
        AST_ONE_EFFECT: assert ($onehot0({rf_we, mem_we, is_branch})); // R2
    end
endmodule

// File: rtl/qc_regfile.sv
module qc_regfile
    import qc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREGS,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_idx,
    input  logic [AW-1:0] rb_idx,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] w_idx,
    input  logic [W-1:0]  w_data
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[w_idx] <= w_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(w_idx)] == $past(w_data)); // R8
endmodule

// File: rtl/qc_pc_unit.sv
module qc_pc_unit
    import qc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_branch,
    input  logic [W-1:0] cond_val,
    input  logic [W-1:0] target_val,
    output logic [W-1:0] pc
);
    logic [W-1:0] pc_next;
    logic         take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    always_comb begin
        take    = is_branch && (cond_val == '0);
        pc_next = take ? target_val : pc + W'(1);
    end

    AST_BZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch && cond_val == '0) |=> pc == $past(target_val)); // R4
    AST_BZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch && cond_val != '0) |=> pc == $past(pc) + W'(1)); // R5
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_branch |=> pc == $past(pc) + W'(1)); // R9
endmodule

// File: rtl/qc_core.sv
module qc_core
    import qc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    input  logic [31:0] dmem_rdata,
    output logic        dmem_we,
    output logic [31:0] dmem_wdata
);
    op_e               op;
    logic [REG_AW-1:0] ra_idx, rb_idx, wr_idx;
    logic              rf_we, wb_from_mem, mem_we, is_branch;
    logic [XLEN-1:0]   ra_data, rb_data, rf_wdata, pc;

    qc_decode u_decode (
        .instr       (imem_rdata),
        .op          (op),
        .ra_idx      (ra_idx),
        .rb_idx      (rb_idx),
        .wr_idx      (wr_idx),
        .rf_we       (rf_we),
        .wb_from_mem (wb_from_mem),
        .mem_we      (mem_we),
        .is_branch   (is_branch)
    );

    qc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (ra_idx),
        .rb_idx  (rb_idx),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .we      (rf_we),
        .w_idx   (wr_idx),
        .w_data  (rf_wdata)
    );

    qc_pc_unit #(.W(XLEN)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_branch  (is_branch),
        .cond_val   (ra_data),
        .target_val (rb_data),
        .pc         (pc)
    );

    always_comb begin
        rf_wdata = wb_from_mem ? dmem_rdata : ra_data + rb_data;
    end

    assign imem_addr  = pc;
    assign dmem_addr  = rb_data;
    assign dmem_wdata = ra_data;
    assign dmem_we    = mem_we;

    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STORE) |-> (dmem_we && !rf_we)); // R7
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=> u_rf.regs[$past(wr_idx)] == $past(ra_data) + $past(rb_data)); // R3
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> u_rf.regs[$past(wr_idx)] == $past(dmem_rdata)); // R6
endmodule

// File: tb/qc_core_tb.sv
`timescale 1ns/1ps
module qc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
    logic        dmem_we;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] enc(input logic [1:0] tag, input int a, input int b,
                                        input int c, input logic [14:0] junk);
        return {tag, 5'(a), 5'(b), 5'(c), junk};
    endfunction

    // Program: tags per R2 (00 ADD, 01 BZ, 10 LOAD, 11 STORE)
    localparam int PLEN = 17;
    localparam logic [31:0] PROG [PLEN] = '{
        enc(2'b10, 1, 0, 0, 15'h0),     // 0  R1 = d[R0]=5
        enc(2'b10, 0, 1, 0, 15'h0),     // 1  R0 = d[5]=3    (R8)
        enc(2'b10, 2, 0, 0, 15'h0),     // 2  R2 = d[3]=-1
        enc(2'b00, 3, 1, 2, 15'h0),     // 3  R3 = 5 + -1 = 4 (wrap)
        enc(2'b00, 1, 1, 1, 15'h0),     // 4  R1 = R1+R1 = 10 (R10)
        enc(2'b11, 1, 3, 0, 15'h0),     // 5  d[4] = 10
        enc(2'b10, 6, 3, 0, 15'h0),     // 6  R6 = d[4] = 10
        enc(2'b10, 7, 1, 0, 15'h0),     // 7  R7 = d[10] = 9
        enc(2'b00, 8, 7, 0, 15'h0),     // 8  R8 = 9+3 = 12
        enc(2'b00, 6, 6, 2, 15'h0),     // 9  R6 = R6-1
        enc(2'b01, 6, 8, 0, 15'h0),     // 10 if R6==0 goto 12
        enc(2'b01, 4, 7, 0, 15'h0),     // 11 goto 9
        enc(2'b11, 6, 0, 0, 15'h0),     // 12 d[3] = 0
        enc(2'b11, 8, 2, 0, 15'h0),     // 13 d[FFFFFFFF] = 12
        enc(2'b00, 9, 8, 8, 15'h7FFF),  // 14 R9 = 24, junk low bits
        enc(2'b10, 10, 8, 0, 15'h5A5A), // 15 R10 = d[12] = 16
        enc(2'b01, 4, 10, 0, 15'h0)     // 16 self loop
    };
    localparam int NEXP = 4;
    localparam int          EXP_IDX [NEXP] = '{4, 3, 63, 0};
    localparam logic [31:0] EXP_VAL [NEXP] = '{32'd10, 32'd0, 32'd12, 32'd5};

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] mrf  [32];
    logic [31:0] md   [64];
    logic [31:0] mpc;

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

    qc_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mrf[i] = '0;
        mpc = '0;
    endtask

    // Called at the falling edge: check this cycle's outputs, then step the model
    task automatic step();
        logic [31:0] ins;
        logic [4:0]  a, b, c;
        ins = imem[mpc[5:0]];
        a = ins[29:25]; b = ins[24:20]; c = ins[19:15];
        chk("R9 imem_addr==pc", imem_addr, mpc);
        case (ins[31:30])
            2'b00: begin
                chk("R3 add no mem write", {31'b0, dmem_we}, 32'd1 - 32'd1);
                mrf[a] = mrf[b] + mrf[c];
                mpc = mpc + 1;
            end
            2'b01: begin
                chk("R5 bz no mem write", {31'b0, dmem_we}, 32'd0);
                if (mrf[a] == 0) mpc = mrf[b];   // R4
                else             mpc = mpc + 1;  // R5
            end
            2'b10: begin
                chk("R6 load address", dmem_addr, mrf[b]);
                chk("R6 load no write", {31'b0, dmem_we}, 32'd0);
                mrf[a] = md[mrf[b][5:0]];
                mpc = mpc + 1;
            end
            default: begin
                chk("R7 store enable", {31'b0, dmem_we}, 32'd1);
                chk("R7 store address", dmem_addr, mrf[b]);
                chk("R7 store data", dmem_wdata, mrf[a]);
                md[mrf[b][5:0]] = mrf[a];
                mpc = mpc + 1;
            end
        endcase
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = (i < PLEN) ? PROG[i] : 32'h0;
            dmem[i] = '0;
        end
        dmem[0] = 32'd5; dmem[3] = 32'hFFFF_FFFF; dmem[5] = 32'd3;
        dmem[10] = 32'd9; dmem[12] = 32'd16;
        for (int i = 0; i < 64; i++) md[i] = dmem[i];
        model_reset();

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'd0);
        chk("R1 no write in reset", {31'b0, dmem_we}, 32'd0);
        chk("R1 operand reg zero", dmem_addr, 32'd0);
        rst_n = 1'b1;

        // Main program, lockstep with the model
        for (int n = 0; n < 70; n++) begin
            step();
            @(negedge clk);
        end

        // R4: parked on the self-branch at 16
        chk("R4 bz self loop pc", imem_addr, 32'd16);
        // R2/R3/R7: final memory image through the normal port
        for (int k = 0; k < NEXP; k++)
            chk("R7 final memory word", dmem[EXP_IDX[k]], EXP_VAL[k]);

        // R1: registers cleared by a second reset, seen through a store
        imem[0] = enc(2'b11, 9, 1, 0, 15'h0);
        rst_n = 1'b0;
        #1;
        chk("R1 pc after reset", imem_addr, 32'd0);
        chk("R1 store of R9 reads zero", dmem_wdata, 32'd0);
        chk("R1 store addr R1 reads zero", dmem_addr, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        for (int n = 0; n < 12; n++) begin
            step();
            @(negedge clk);
        end
        chk("R1 reset store landed", dmem[0], 32'd0);

        finish_run();
    end
endmodule